// File: doc/BRIEF.md
# Pixel Configuration Register with Test-Mode Decoder

This block keeps the per-pixel settings of a counting pixel in an imaging matrix. The periphery loads the settings one bit at a time into an 11-stage shift chain. The pixel keeps running on its previous settings while this happens. A separate load strobe then copies the whole chain into a holding stage in one step, so the active settings change only at that moment. The last chain stage drives a serial output, which lets the registers of many pixels be daisy-chained along a column.

The held word has three fields. The first is a 4-bit trim code for the lower-threshold comparator DAC, the second a 4-bit trim code for the upper-threshold comparator DAC, and the third a 3-bit operating-mode code. A decoder turns the mode code into the digital switch controls: a one-hot test-path selection, a one-hot choice of the comparator reference (threshold, baseline or ground) and a counter-connect enable. The analog DACs and switches sit outside this block.

An active-low reset clears both stages at once, without waiting for a clock edge. Its release is synchronised to the clock. After reset the pixel is in normal mode with both trims at zero.

Top module: `pixcfg_reg`

## Requirements
- R1: While `rst_n` is low, both stages clear without waiting for a clock edge. After reset, `trim_lo`=0, `trim_hi`=0, `test_sel`=6'b000001, `ref_sel`=3'b001, `cnt_conn`=1 and `sout`=0.
- R2: On each clock edge with `shift_en` high, the chain moves one place: `sin` enters stage 0 and stage k takes the old value of stage k-1. `sout` is stage 10. With `shift_en` low the chain holds. After an 11-bit word has been shifted in most-significant bit first, `sout` equals bit 10 of that word.
- R3: Shifting never changes `trim_lo`, `trim_hi`, `test_sel`, `ref_sel` or `cnt_conn`. These outputs change only on an edge where `load_en` is high.
- R4: On an edge with `load_en` high, the chain is copied to the holding stage. Chain bits [3:0] drive `trim_lo`, bits [7:4] drive `trim_hi`, and bits [10:8] form the mode code.
- R5: If `load_en` and `shift_en` are both high on the same edge, the holding stage captures the chain contents from before that shift.
- R6: `test_sel` is one-hot with bit 0 normal, bit 1 analog monitor, bit 2 test-charge injection, bit 3 lower-DAC calibration, bit 4 upper-DAC calibration and bit 5 pixel off. Mode codes 000, 001, 010, 011, 100 and 111 select these bits in that order.
- R7: The unused mode codes 101 and 110 produce exactly the outputs of code 000.
- R8: `ref_sel` is one-hot with bit 0 threshold, bit 1 baseline and bit 2 ground. Codes 011 and 100 select the baseline, code 111 selects ground, and every other code selects the threshold.
- R9: `cnt_conn` is 1 for codes 000, 010, 101 and 110, and 0 for all other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock |
| rst_n | input | 1 | Active-low clear; clears without a clock edge, release is synchronised |
| shift_en | input | 1 | Shift the chain by one stage on this edge |
| sin | input | 1 | Serial configuration data in |
| load_en | input | 1 | Copy the chain into the holding stage on this edge |
| sout | output | 1 | Last chain stage, for daisy-chaining |
| trim_lo | output | 4 | Held lower-threshold DAC trim |
| trim_hi | output | 4 | Held upper-threshold DAC trim |
| test_sel | output | 6 | One-hot test/calibration switch controls |
| ref_sel | output | 3 | One-hot comparator reference selection |
| cnt_conn | output | 1 | Connects the counter to the discriminator |

## Verification
A corrupted chain stage shows first at `sout`. The bad bit appears there after as many further shift edges as the stage is away from the end, and it reaches the held outputs on the next load. A holding stage that drifts without a load, or that captures the chain one shift too late, shows on the trim and mode outputs on the edge just after the strobe. A decoder fault shows at the same moment as a second or missing hot bit, or as a wrong reference for the code that was loaded. For this reason every mode code, including the two unused ones, is loaded and compared on its own.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;

  localparam int MODE_W = 3;
  localparam int SEL_W  = 6;
  localparam int REF_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 3'b000,
    MODE_MON    = 3'b001,
    MODE_INJ    = 3'b010,
    MODE_CAL_LO = 3'b011,
    MODE_CAL_HI = 3'b100,
    MODE_SPR_A  = 3'b101,
    MODE_SPR_B  = 3'b110,
    MODE_OFF    = 3'b111
  } mode_e;

  // test_sel bit positions
  localparam int SEL_RUN    = 0;
  localparam int SEL_MON    = 1;
  localparam int SEL_INJ    = 2;
  localparam int SEL_CAL_LO = 3;
  localparam int SEL_CAL_HI = 4;
  localparam int SEL_OFF    = 5;

  // ref_sel bit positions
  localparam int REF_THR  = 0;
  localparam int REF_BASE = 1;
  localparam int REF_GND  = 2;

  typedef struct packed {
    logic [SEL_W-1:0] test_sel;
    logic [REF_W-1:0] ref_sel;
    logic             cnt_conn;
  } ctrl_t;

endpackage

// File: rtl/pixcfg_chain.sv
module pixcfg_chain #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic [N-1:0] chain_q
);

  logic [N-1:0] chain_d;

  // one stage per bit, each with its own enable and clear
  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb chain_d[k] = shift_en ? sin : chain_q[k];
    end else begin : g_body
      always_comb chain_d[k] = shift_en ? chain_q[k-1] : chain_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[k] <= 1'b0;
      else        chain_q[k] <= chain_d[k];
    end
  end

  // R2
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));

  // R2
  chain_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (chain_q[N-1:1] == $past(chain_q[N-2:0])) && (chain_q[0] == $past(sin)));

endmodule

// File: rtl/pixcfg_shadow.sv
module pixcfg_shadow #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] cfg_in,
  output logic [N-1:0] held_q
);

  logic [N-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (load_en) held_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(held_q));

  // R4
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> held_q == $past(cfg_in));

endmodule

// File: rtl/pixcfg_decode.sv
module pixcfg_decode
  import pixcfg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_code,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.cnt_conn = 1'b0;
    unique case (mode_e'(mode_code))
      MODE_MON: begin
        ctrl.test_sel[SEL_MON] = 1'b1;
        ctrl.ref_sel[REF_THR]  = 1'b1;
      end
      MODE_INJ: begin
        ctrl.test_sel[SEL_INJ] = 1'b1;
        ctrl.ref_sel[REF_THR]  = 1'b1;
        ctrl.cnt_conn          = 1'b1;
      end
      MODE_CAL_LO: begin
        ctrl.test_sel[SEL_CAL_LO] = 1'b1;
        ctrl.ref_sel[REF_BASE]    = 1'b1;
      end
      MODE_CAL_HI: begin
        ctrl.test_sel[SEL_CAL_HI] = 1'b1;
        ctrl.ref_sel[REF_BASE]    = 1'b1;
      end
      MODE_OFF: begin
        ctrl.test_sel[SEL_OFF] = 1'b1;
        ctrl.ref_sel[REF_GND]  = 1'b1;
      end
      default: begin
        // normal, and the two unused codes fall back to it
        ctrl.test_sel[SEL_RUN] = 1'b1;
        ctrl.ref_sel[REF_THR]  = 1'b1;
        ctrl.cnt_conn          = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pixcfg_reg.sv
module pixcfg_reg
  import pixcfg_pkg::*;
#(
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sin,
  input  logic              load_en,
  output logic              sout,
  output logic [TRIM_W-1:0] trim_lo,
  output logic [TRIM_W-1:0] trim_hi,
  output logic [SEL_W-1:0]  test_sel,
  output logic [REF_W-1:0]  ref_sel,
  output logic              cnt_conn
);

  localparam int CFG_W   = 2 * TRIM_W + MODE_W;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = TRIM_W;
  localparam int MD_LSB  = 2 * TRIM_W;

  // reset: asserts at once, releases on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [CFG_W-1:0]  chain_q;
  logic [CFG_W-1:0]  held_q;
  logic [MODE_W-1:0] mode_code;
  ctrl_t             ctrl;

  pixcfg_chain #(.N(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .shift_en (shift_en),
    .sin      (sin),
    .chain_q  (chain_q)
  );

  pixcfg_shadow #(.N(CFG_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .load_en (load_en),
    .cfg_in  (chain_q),
    .held_q  (held_q)
  );

  assign mode_code = held_q[MD_LSB +: MODE_W];

  pixcfg_decode u_decode (
    .mode_code (mode_code),
    .ctrl      (ctrl)
  );

  assign sout     = chain_q[CFG_W-1];
  assign trim_lo  = held_q[LO_LSB +: TRIM_W];
  assign trim_hi  = held_q[HI_LSB +: TRIM_W];
  assign test_sel = ctrl.test_sel;
  assign ref_sel  = ctrl.ref_sel;
  assign cnt_conn = ctrl.cnt_conn;

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $countones(test_sel) == 1);

  // R8
  ref_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $countones(ref_sel) == 1);

  // R8
  off_ground_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    test_sel[SEL_OFF] |-> ref_sel[REF_GND] && !cnt_conn);

  // R3
  trim_stable_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !load_en |=> $stable(trim_lo) && $stable(trim_hi) && $stable(test_sel));

endmodule

// File: tb/pixcfg_reg_tb.sv
module pixcfg_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n, shift_en, sin, load_en;
  logic       sout, cnt_conn;
  logic [3:0] trim_lo, trim_hi;
  logic [5:0] test_sel;
  logic [2:0] ref_sel;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pixcfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sin(sin), .load_en(load_en),
    .sout(sout), .trim_lo(trim_lo), .trim_hi(trim_hi), .test_sel(test_sel),
    .ref_sel(ref_sel), .cnt_conn(cnt_conn)
  );

  // word[10:0], expected test_sel, ref_sel, cnt_conn
  localparam logic [20:0] VEC [8] = '{
    {11'h05A, 6'b000001, 3'b001, 1'b1},
    {11'h13C, 6'b000010, 3'b001, 1'b0},
    {11'h2F0, 6'b000100, 3'b001, 1'b1},
    {11'h30F, 6'b001000, 3'b010, 1'b0},
    {11'h496, 6'b010000, 3'b010, 1'b0},
    {11'h571, 6'b000001, 3'b001, 1'b1},
    {11'h6E2, 6'b000001, 3'b001, 1'b1},
    {11'h7A5, 6'b100000, 3'b100, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [10:0] w);
    for (int i = 10; i >= 0; i--) begin
      @(negedge clk);
      sin = w[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
    sin = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic check_outputs(input string req, input logic [10:0] w,
                               input logic [5:0] es, input logic [2:0] er, input logic ec);
    check({req, " trim_lo"}, 32'(trim_lo), 32'(w[3:0]));
    check({req, " trim_hi"}, 32'(trim_hi), 32'(w[7:4]));
    check({req, " test_sel"}, 32'(test_sel), 32'(es));
    check({req, " ref_sel"}, 32'(ref_sel), 32'(er));
    check({req, " cnt_conn"}, 32'(cnt_conn), 32'(ec));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    logic [10:0] prev_w;
    rst_n = 1'b0; shift_en = 1'b0; sin = 1'b0; load_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outputs("R1 reset", 11'h000, 6'b000001, 3'b001, 1'b1);
    check("R1 sout", 32'(sout), 32'd0);

    // table walk: every mode code, R6 R7 R8 R9 and R2 R3 R4
    prev_w = 11'h000;
    for (int v = 0; v < 8; v++) begin
      logic [10:0] w;
      w = VEC[v][20:10];
      shift_word(w);
      check("R2 sout after word", 32'(sout), 32'(w[10]));
      check("R3 trim_lo before load", 32'(trim_lo), 32'(prev_w[3:0]));
      check("R3 trim_hi before load", 32'(trim_hi), 32'(prev_w[7:4]));
      pulse_load();
      check_outputs("R4 R6 R7 R8 R9 load", w, VEC[v][9:4], VEC[v][3:1], VEC[v][0]);
      prev_w = w;
    end

    // R2 hold: shift_en low leaves the chain alone
    shift_word(11'h13C);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sin = i[0];
    end
    check("R2 sout held", 32'(sout), 32'd0);
    pulse_load();
    check_outputs("R2 hold then load", 11'h13C, 6'b000010, 3'b001, 1'b0);

    // R2 daisy chain: one more shift exposes bit 9
    shift_word(11'h496);
    @(negedge clk);
    sin = 1'b1; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    check("R2 sout next bit", 32'(sout), 32'd0);

    // R5 load and shift on the same edge take pre-shift contents
    shift_word(11'h7A5);
    @(negedge clk);
    sin = 1'b1; shift_en = 1'b1; load_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; load_en = 1'b0;
    check_outputs("R5 simultaneous", 11'h7A5, 6'b100000, 3'b100, 1'b0);
    pulse_load();
    // chain was 7A5 shifted left with a 1: 0x74B -> mode 111 still, trims 4/B
    check_outputs("R5 next load", 11'h74B, 6'b100000, 3'b100, 1'b0);

    // R1 clear without a clock edge
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check_outputs("R1 async clear", 11'h000, 6'b000001, 3'b001, 1'b1);
    check("R1 async sout", 32'(sout), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outputs("R1 after release", 11'h000, 6'b000001, 3'b001, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule